// File: doc/BRIEF.md
# Latched Four-Level Segment Output Selector

This block sits between a serial-to-parallel shift stage and the analog segment switches of a dot-matrix display driver. It takes the parallel contents of the shift stage as an input vector, holds them in a per-segment latch, and gives every segment a 2-bit code. The code names one of four drive rails. The rail depends on the segment's on/off bit and on a frame alternation signal, so each segment sees an AC waveform with no DC bias.

The latch is transparent while its strobe is high. During that time the outputs follow the incoming vector, and the register samples the vector on every clock edge. When the strobe is low, the register keeps the last sampled vector. The alternation input is combinational: changing it moves every output to the opposite-polarity rail at once, with no new strobe.

Top module: `seg_level_top`

## Requirements
- R1: While reset is asserted, and afterwards until a strobe is seen, the latch holds all zeros. Every segment therefore shows a non-selected code: 2'b01 when alternation is low and 2'b10 when it is high.
- R2: While the strobe is high, each segment's code is derived in the same cycle from the current input vector bit.
- R3: While the strobe is low, changes on the input vector have no effect on any output.
- R4: At each rising clock edge with the strobe high, the latch stores the input vector. After the strobe falls, the outputs show the vector sampled at the last edge where the strobe was high.
- R5: A selected segment (bit 1) outputs 2'b11 (lowest rail) when alternation is high and 2'b00 (highest rail) when it is low.
- R6: A non-selected segment (bit 0) outputs 2'b10 (third rail) when alternation is high and 2'b01 (second rail) when it is low.
- R7: A change of the alternation input changes the outputs in the same cycle, with no strobe. With the data fixed, it inverts both bits of every code.
- R8: Segment k uses bit k of the vector and only that bit. Its code sits at bits [2k+1:2k] of the output bus, for k from 0 to NUM_SEG-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the latch |
| strobe_i | input | 1 | Latch strobe: high makes the latch transparent, low holds it |
| alt_i | input | 1 | Frame alternation signal |
| shift_data_i | input | NUM_SEG | Parallel contents of the shift stage; bit k belongs to segment k |
| seg_level_o | output | 2*NUM_SEG | Per-segment rail code; segment k at [2k+1:2k] |

## Verification
Two things can happen in the same cycle. The strobe can fall, which hands the outputs from live data to held data, while the alternation input also flips and the input vector changes. The bench provokes this with a long stretch of random strobe, alternation and data values, driven together on the falling clock edge. It judges every cycle against a behavioural model that keeps its own copy of the last value sampled with the strobe high. Flipping alternation while the strobe is low is also checked on its own. That check confirms the codes invert and the latch contents do not move.

// File: rtl/seg_level_pkg.sv
package seg_level_pkg;

  localparam int LVL_W = 2;

  typedef enum logic [LVL_W-1:0] {
    RAIL_TOP    = 2'b00,
    RAIL_SECOND = 2'b01,
    RAIL_THIRD  = 2'b10,
    RAIL_BOTTOM = 2'b11
  } rail_e;

  // Rail choice for one segment from its on/off bit and the alternation phase.
  function automatic rail_e pick_rail(input logic seg_on, input logic phase);
    rail_e r;
    case ({seg_on, phase})
      2'b11:   r = RAIL_BOTTOM;
      2'b10:   r = RAIL_TOP;
      2'b01:   r = RAIL_THIRD;
      default: r = RAIL_SECOND;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/seg_hold_latch.sv
module seg_hold_latch #(
  parameter int WIDTH = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] eff_o,
  output logic [WIDTH-1:0] held_o
);

  logic [WIDTH-1:0] held_q;
  logic             load_evt;

  assign load_evt = strobe_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        held_q <= '0;
    else if (load_evt) held_q <= data_i;
  end

  // Transparent while the strobe is high, holding otherwise.
  assign eff_o  = strobe_i ? data_i : held_q;
  assign held_o = held_q;

  // R4: the vector present at a strobed edge is what the latch holds next
  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i |=> (held_q == $past(data_i)));

  // R3: without a strobe the latch contents do not move
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> $stable(held_q));

endmodule

// File: rtl/seg_level_encoder.sv
module seg_level_encoder
  import seg_level_pkg::*;
#(
  parameter int NUM_SEG = 80
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SEG-1:0]       seg_on_i,
  input  logic                     phase_i,
  output logic [LVL_W*NUM_SEG-1:0] level_o
);

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    rail_e rail;
    assign rail = pick_rail(seg_on_i[k], phase_i);
    assign level_o[LVL_W*k +: LVL_W] = rail;
  end

  // R5: a selected first segment swings between the top and bottom rails
  p_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seg_on_i[0] |-> (level_o[1:0] == {phase_i, phase_i}));

  // R6: a non-selected first segment stays on the two middle rails
  p_nonsel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_on_i[0] |-> (level_o[1] != level_o[0]));

endmodule

// File: rtl/seg_level_top.sv
module seg_level_top
  import seg_level_pkg::*;
#(
  parameter int NUM_SEG = 80
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     strobe_i,
  input  logic                     alt_i,
  input  logic [NUM_SEG-1:0]       shift_data_i,
  output logic [LVL_W*NUM_SEG-1:0] seg_level_o
);

  localparam int BUS_W = LVL_W * NUM_SEG;

  logic [NUM_SEG-1:0] eff_data;
  logic [NUM_SEG-1:0] held_data;

  seg_hold_latch #(.WIDTH(NUM_SEG)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (strobe_i),
    .data_i   (shift_data_i),
    .eff_o    (eff_data),
    .held_o   (held_data)
  );

  seg_level_encoder #(.NUM_SEG(NUM_SEG)) u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .seg_on_i (eff_data),
    .phase_i  (alt_i),
    .level_o  (seg_level_o)
  );

  // R2: with the strobe high the last segment tracks the live input bit
  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i |-> (seg_level_o[BUS_W-1:BUS_W-2] ==
                  {alt_i, ~(shift_data_i[NUM_SEG-1] ^ alt_i)}));

  // R7: a phase flip with the latch held inverts every code
  p_alt_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_i && !$past(strobe_i) && (alt_i != $past(alt_i)))
      |-> (seg_level_o == ~$past(seg_level_o)));

  // R3: held data drives the outputs when the strobe is low
  p_held_view_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |-> (seg_level_o[1:0] == {alt_i, ~(held_data[0] ^ alt_i)}));

endmodule

// File: tb/seg_level_top_tb.sv
module seg_level_top_tb;

  localparam int NSEG = 80;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              strobe_i = 1'b0;
  logic              alt_i = 1'b0;
  logic [NSEG-1:0]   shift_data_i = '0;
  logic [2*NSEG-1:0] seg_level_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [NSEG-1:0] model_held;

  seg_level_top #(.NUM_SEG(NSEG)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe_i     (strobe_i),
    .alt_i        (alt_i),
    .shift_data_i (shift_data_i),
    .seg_level_o  (seg_level_o)
  );

  always #5 clk = ~clk;

  // Behavioural model of the held contents.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)        model_held = '0;
    else if (strobe_i) model_held = shift_data_i;
  end

  function automatic int expect_code(input bit on, input bit ph);
    if (on) return ph ? 3 : 0;
    return ph ? 2 : 1;
  endfunction

  task automatic check_all(input string tag);
    int bad = -1;
    int act = 0;
    int exp = 0;
    for (int k = 0; k < NSEG; k++) begin
      bit on;
      int e;
      int a;
      on = strobe_i ? shift_data_i[k] : model_held[k];
      e  = expect_code(on, alt_i);
      a  = int'(seg_level_o[2*k +: 2]);
      if (a != e && bad < 0) begin
        bad = k;
        act = a;
        exp = e;
      end
    end
    n_tests++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s seg %0d actual %0d expected %0d", tag, bad, act, exp);
    end
  endtask

  task automatic step(input bit s, input bit a, input logic [NSEG-1:0] d, input string tag);
    @(negedge clk);
    strobe_i     = s;
    alt_i        = a;
    shift_data_i = d;
    #2;
    check_all(tag);
  endtask

  logic [NSEG-1:0] pat_a;
  logic [NSEG-1:0] pat_b;

  initial begin
    pat_a = {NSEG/8{8'hA5}};
    pat_b = {NSEG/8{8'h3C}};
    // R1: reset state, both phases
    step(0, 0, pat_a, "R1");
    step(0, 1, pat_a, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, pat_a, "R1");
    step(0, 1, pat_b, "R3");
    // R2: pass-through while strobed
    step(1, 0, pat_a, "R2");
    step(1, 1, pat_b, "R2");
    // R4: last strobed value shows after the strobe falls
    step(0, 1, ~pat_b, "R4");
    // R7: phase flips without a strobe
    step(0, 0, ~pat_b, "R7");
    step(0, 1, pat_a, "R7");
    // R3: data changes while held
    step(0, 1, '0, "R3");
    step(0, 1, '1, "R3");
    // R5: all selected
    step(1, 0, '1, "R5");
    step(0, 0, '0, "R5");
    step(0, 1, '0, "R5");
    // R6: all non-selected
    step(1, 1, '0, "R6");
    step(0, 1, '1, "R6");
    step(0, 0, '1, "R6");
    // R8: walking one, position mapping
    for (int k = 0; k < NSEG; k++) begin
      step(1, k[0], {{(NSEG-1){1'b0}}, 1'b1} << k, "R8");
    end
    step(0, 0, '0, "R8");
    // Strobe edge, phase flip and data change in the same cycle
    for (int i = 0; i < 400; i++) begin
      logic [NSEG-1:0] d;
      for (int w = 0; w < NSEG; w += 32) d[w +: 32] = $urandom();
      step(1'($urandom()), 1'($urandom()), d, "R7");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule